// File: doc/BRIEF.md
# Magnetometer Acquisition Scheduler

This block decides when a magnetic-field acquisition begins and how long it keeps the conversion path occupied. It counts time in ticks of a timebase enable, and from an enable bit, a one-shot trigger bit, a 3-bit rate code and a 2-bit oversampling code it issues a one-cycle start pulse, holds a busy flag for the conversion window, and emits a one-cycle done pulse when the window closes. The done pulse is the moment the surrounding logic refreshes its result registers. The conversion engine itself is not part of the block.

The spacing between starts is the base interval multiplied by the oversampling ratio and by two to the power of the rate code. The busy window is one conversion slot per oversample. A one-shot trigger runs a single acquisition immediately when the block is idle in standby. In continuous mode it first waits for the running acquisition, then runs one at the shortest spacing the oversampling allows, and after that the programmed rate resumes. The block also sequences the magnetic sensor reset cycle, both on request and automatically before every acquisition, and it reports a 2-bit operating-mode code.

Top module: `mag_meas_sched`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, start, busy, done, trigger bit and reset bit read 0 and the mode code reads 00.
- R2: With `active_i`=0 and no trigger request, no start pulse is issued however long the block waits.
- R3: With `active_i`=1, successive start pulses are exactly BASE_TICKS x 2^osr x 2^rate ticks apart, where the oversampling codes 0, 1, 2 and 3 mean ratios 1, 2, 4 and 8. Only cycles with `tick_en_i` high count.
- R4: `meas_busy_o` is high from the start-pulse cycle for SLOT_TICKS x ratio ticks. `meas_done_o` is high for one cycle, in the first cycle after busy falls.
- R5: A trigger request captured in standby while idle gives a start pulse in the next cycle, and exactly one acquisition runs. No further start follows.
- R6: A trigger request in continuous mode lets the running acquisition finish. The next start then comes BASE_TICKS x ratio ticks after the previous start, and the following start comes one programmed period after that.
- R7: `trig_bit_o` rises on a request and stays 1 until the done pulse of the triggered acquisition, in which cycle it reads 0. A further request while it is 1 is not queued.
- R8: `sysmod_o` reads 00 in standby and reads 01 (`raw_i`=1) or 10 (`raw_i`=0) while continuous mode is on or an acquisition or reset sequence is running. It never reads 11.
- R9: A request on `srst_set_i` sets `srst_bit_o`. In standby the bit stays 1 for RST_TICKS+1 ticks and then returns to 0 by itself without starting an acquisition.
- R10: With `auto_rst_i`=1, a reset cycle of RST_TICKS ticks precedes every start: `srst_bit_o` is 1 in the cycle before each start pulse and 0 during it. The start spacing is unchanged.
- R11: Clearing `active_i` during an acquisition leaves its busy window at full length with its done pulse. No further start follows and the mode returns to 00.
- R12: If a reset request is pending on the cycle a periodic start falls due, one reset cycle runs and the start comes RST_TICKS ticks late. The start after that keeps the original period grid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en_i | input | 1 | Timebase enable; one tick per high cycle |
| active_i | input | 1 | Continuous acquisition enable |
| trig_set_i | input | 1 | One-cycle request to set the trigger bit |
| rate_code_i | input | 3 | Rate code, period doubles per step |
| osr_code_i | input | 2 | Oversampling code, ratio 2^code |
| raw_i | input | 1 | Selects uncorrected output data (mode code only) |
| auto_rst_i | input | 1 | Insert a sensor reset cycle before every acquisition |
| srst_set_i | input | 1 | One-cycle request to set the sensor reset bit |
| meas_start_o | output | 1 | One-cycle start-of-acquisition pulse |
| meas_busy_o | output | 1 | Conversion window in progress |
| meas_done_o | output | 1 | One-cycle end-of-acquisition pulse |
| trig_bit_o | output | 1 | Trigger bit readback, self-clearing |
| srst_bit_o | output | 1 | Sensor reset bit readback, self-clearing |
| sysmod_o | output | 2 | Operating-mode code |

## Verification
Two functions can land in the same cycle: a sensor reset request becoming pending, and a periodic start falling due. The bench counts cycles from a start and raises the reset request exactly one edge before the next due launch, so both are seen together. A correct design merges them. The start arrives RST_TICKS late and the start after it lands back on the original grid. A design that serves the reset first and defers the launch drifts the grid, and that second spacing catches it. Random rate, oversampling and auto-reset settings, plus a phase with a gapped tick, exercise the period arithmetic around these directed cases.

// File: rtl/mag_sched_pkg.sv
package mag_sched_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RSTC = 2'd1,
    ST_MEAS = 2'd2
  } sched_st_e;

  localparam logic [1:0] MODE_STANDBY = 2'b00;
  localparam logic [1:0] MODE_RAW     = 2'b01;
  localparam logic [1:0] MODE_CORR    = 2'b10;

  function automatic logic [1:0] mode_code(input logic running, input logic raw);
    if (!running) return MODE_STANDBY;
    return raw ? MODE_RAW : MODE_CORR;
  endfunction

endpackage

// File: rtl/mag_rate_calc.sv
module mag_rate_calc #(
  parameter int BASE_TICKS = 8,
  parameter int SLOT_TICKS = 4,
  parameter int RATE_W     = 3,
  parameter int OSR_W      = 2,
  parameter int PER_W      = 14,
  parameter int BUSY_W     = 6
) (
  input  logic [RATE_W-1:0] rate_code_i,
  input  logic [OSR_W-1:0]  osr_code_i,
  output logic [PER_W-1:0]  prog_period_o,
  output logic [PER_W-1:0]  fast_period_o,
  output logic [BUSY_W-1:0] busy_ticks_o
);

  localparam logic [PER_W-1:0]  BASE_V = PER_W'(BASE_TICKS);
  localparam logic [BUSY_W-1:0] SLOT_V = BUSY_W'(SLOT_TICKS);

  // Ratio and rate are both powers of two, so the product is one shift.
  always_comb begin
    prog_period_o = BASE_V << (int'(osr_code_i) + int'(rate_code_i));
    fast_period_o = BASE_V << osr_code_i;
    busy_ticks_o  = SLOT_V << osr_code_i;
  end

endmodule

// File: rtl/mag_period_counter.sv
module mag_period_counter #(
  parameter int PER_W = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic             restart_i,
  output logic [PER_W-1:0] cnt_o
);

  localparam logic [PER_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk) begin
    if (rst)                          cnt_o <= '1;
    else if (restart_i)               cnt_o <= '0;
    else if (tick_i && cnt_o != CNT_MAX) cnt_o <= cnt_o + 1'b1;
  end

  a_r3_restart_zero: assert property (@(posedge clk) disable iff (rst)
    restart_i |=> (cnt_o == '0));

endmodule

// File: rtl/mag_sched_fsm.sv
module mag_sched_fsm
  import mag_sched_pkg::*;
#(
  parameter int RST_TICKS = 3,
  parameter int PER_W     = 14,
  parameter int BUSY_W    = 6,
  parameter int PH_W      = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic              active_i,
  input  logic              trig_set_i,
  input  logic              srst_set_i,
  input  logic              auto_rst_i,
  input  logic              raw_i,
  input  logic [PER_W-1:0]  per_cnt_i,
  input  logic [PER_W-1:0]  prog_period_i,
  input  logic [PER_W-1:0]  fast_period_i,
  input  logic [BUSY_W-1:0] busy_ticks_i,
  output logic              launch_o,
  output logic              start_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              trig_bit_o,
  output logic              srst_bit_o,
  output logic [1:0]        sysmod_o
);

  localparam logic [PH_W-1:0] RST_LAST = PH_W'(RST_TICKS - 1);

  sched_st_e       st_q, st_n;
  logic [PH_W-1:0] ph_q, ph_n;
  logic            trig_pend_q, trig_pend_n;
  logic            trig_run_q, trig_run_n;
  logic            srst_pend_q, srst_pend_n;
  logic            then_meas_q, then_meas_n;
  logic            due_prog, due_fast, rst_end, meas_end;
  logic [PH_W-1:0] busy_last;

  assign busy_last = PH_W'(busy_ticks_i) - PH_W'(1);
  assign due_prog  = active_i && tick_i && (per_cnt_i >= prog_period_i - 1'b1);
  assign due_fast  = active_i && tick_i && (per_cnt_i >= fast_period_i - 1'b1);

  // Trigger overrides the programmed period; in standby it goes at once.
  assign launch_o = (st_q == ST_IDLE) &&
                    (trig_pend_q ? (active_i ? due_fast : 1'b1) : due_prog);

  always_comb begin
    st_n        = st_q;
    then_meas_n = then_meas_q;
    rst_end     = 1'b0;
    meas_end    = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (launch_o) begin
          st_n        = (auto_rst_i || srst_pend_q) ? ST_RSTC : ST_MEAS;
          then_meas_n = 1'b1;
        end else if (srst_pend_q) begin
          st_n        = ST_RSTC;
          then_meas_n = 1'b0;
        end
      end
      ST_RSTC: begin
        if (tick_i && ph_q == RST_LAST) begin
          rst_end = 1'b1;
          st_n    = then_meas_q ? ST_MEAS : ST_IDLE;
        end
      end
      ST_MEAS: begin
        if (tick_i && ph_q == busy_last) begin
          meas_end = 1'b1;
          st_n     = ST_IDLE;
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_comb begin
    if (st_n != st_q) ph_n = '0;
    else if (tick_i)  ph_n = ph_q + 1'b1;
    else              ph_n = ph_q;

    trig_run_n = trig_run_q;
    if (launch_o)      trig_run_n = trig_pend_q;
    else if (meas_end) trig_run_n = 1'b0;

    if (meas_end && trig_run_q) trig_pend_n = 1'b0;
    else                        trig_pend_n = trig_pend_q | trig_set_i;

    if (rst_end) srst_pend_n = 1'b0;
    else         srst_pend_n = srst_pend_q | srst_set_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= ST_IDLE;
      ph_q        <= '0;
      trig_pend_q <= 1'b0;
      trig_run_q  <= 1'b0;
      srst_pend_q <= 1'b0;
      then_meas_q <= 1'b0;
      start_o     <= 1'b0;
      done_o      <= 1'b0;
      srst_bit_o  <= 1'b0;
      sysmod_o    <= MODE_STANDBY;
    end else begin
      st_q        <= st_n;
      ph_q        <= ph_n;
      trig_pend_q <= trig_pend_n;
      trig_run_q  <= trig_run_n;
      srst_pend_q <= srst_pend_n;
      then_meas_q <= then_meas_n;
      start_o     <= (st_n == ST_MEAS) && (st_q != ST_MEAS);
      done_o      <= meas_end;
      srst_bit_o  <= srst_pend_n || (st_n == ST_RSTC);
      sysmod_o    <= mode_code(active_i || st_n != ST_IDLE, raw_i);
    end
  end

  assign busy_o     = (st_q == ST_MEAS);
  assign trig_bit_o = trig_pend_q;

  a_r4_start_in_busy: assert property (@(posedge clk) disable iff (rst)
    start_o |-> busy_o);
  a_r4_done_closes_busy: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (!busy_o && $past(busy_o)));
  a_r7_trig_clears_at_done: assert property (@(posedge clk) disable iff (rst)
    $fell(trig_bit_o) |-> done_o);
  a_r10_reset_over_at_start: assert property (@(posedge clk) disable iff (rst)
    start_o |-> !srst_bit_o);
  a_r8_mode_legal: assert property (@(posedge clk) disable iff (rst)
    sysmod_o != 2'b11);

endmodule

// File: rtl/mag_meas_sched.sv
module mag_meas_sched #(
  parameter int BASE_TICKS = 8,
  parameter int SLOT_TICKS = 4,
  parameter int RST_TICKS  = 3,
  parameter int RATE_W     = 3,
  parameter int OSR_W      = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en_i,
  input  logic              active_i,
  input  logic              trig_set_i,
  input  logic [RATE_W-1:0] rate_code_i,
  input  logic [OSR_W-1:0]  osr_code_i,
  input  logic              raw_i,
  input  logic              auto_rst_i,
  input  logic              srst_set_i,
  output logic              meas_start_o,
  output logic              meas_busy_o,
  output logic              meas_done_o,
  output logic              trig_bit_o,
  output logic              srst_bit_o,
  output logic [1:0]        sysmod_o
);

  localparam int OSR_MAX_LOG  = (1 << OSR_W) - 1;
  localparam int RATE_MAX_LOG = (1 << RATE_W) - 1;
  localparam int PER_W  = $clog2(BASE_TICKS) + OSR_MAX_LOG + RATE_MAX_LOG + 1;
  localparam int BUSY_W = $clog2(SLOT_TICKS) + OSR_MAX_LOG + 1;
  localparam int RSTC_W = $clog2(RST_TICKS + 1);
  localparam int PH_W   = (BUSY_W > RSTC_W) ? BUSY_W : RSTC_W;

  logic [PER_W-1:0]  prog_period, fast_period, per_cnt;
  logic [BUSY_W-1:0] busy_ticks;
  logic              launch;

  mag_rate_calc #(
    .BASE_TICKS(BASE_TICKS), .SLOT_TICKS(SLOT_TICKS), .RATE_W(RATE_W),
    .OSR_W(OSR_W), .PER_W(PER_W), .BUSY_W(BUSY_W)
  ) u_rate (
    .rate_code_i  (rate_code_i),
    .osr_code_i   (osr_code_i),
    .prog_period_o(prog_period),
    .fast_period_o(fast_period),
    .busy_ticks_o (busy_ticks)
  );

  mag_period_counter #(.PER_W(PER_W)) u_per (
    .clk      (clk),
    .rst      (rst),
    .tick_i   (tick_en_i),
    .restart_i(launch),
    .cnt_o    (per_cnt)
  );

  mag_sched_fsm #(
    .RST_TICKS(RST_TICKS), .PER_W(PER_W), .BUSY_W(BUSY_W), .PH_W(PH_W)
  ) u_fsm (
    .clk          (clk),
    .rst          (rst),
    .tick_i       (tick_en_i),
    .active_i     (active_i),
    .trig_set_i   (trig_set_i),
    .srst_set_i   (srst_set_i),
    .auto_rst_i   (auto_rst_i),
    .raw_i        (raw_i),
    .per_cnt_i    (per_cnt),
    .prog_period_i(prog_period),
    .fast_period_i(fast_period),
    .busy_ticks_i (busy_ticks),
    .launch_o     (launch),
    .start_o      (meas_start_o),
    .busy_o       (meas_busy_o),
    .done_o       (meas_done_o),
    .trig_bit_o   (trig_bit_o),
    .srst_bit_o   (srst_bit_o),
    .sysmod_o     (sysmod_o)
  );

endmodule

// File: tb/mag_meas_sched_bench.sv
`timescale 1ns/1ps
module mag_meas_sched_bench;

  localparam int BASE = 8;
  localparam int SLOT = 4;
  localparam int RSTT = 3;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_en_i = 1'b1;
  logic       active_i = 1'b0, trig_set_i = 1'b0, raw_i = 1'b0;
  logic       auto_rst_i = 1'b0, srst_set_i = 1'b0;
  logic [2:0] rate_code_i = '0;
  logic [1:0] osr_code_i = '0;
  logic       meas_start_o, meas_busy_o, meas_done_o, trig_bit_o, srst_bit_o;
  logic [1:0] sysmod_o;

  int  n_chk = 0, n_fail = 0, cyc = 0;
  bit  gap_mode = 1'b0;
  bit  finished = 1'b0;

  mag_meas_sched #(.BASE_TICKS(BASE), .SLOT_TICKS(SLOT), .RST_TICKS(RSTT)) u_mag_meas_sched (
    .clk(clk), .rst(rst), .tick_en_i(tick_en_i), .active_i(active_i),
    .trig_set_i(trig_set_i), .rate_code_i(rate_code_i), .osr_code_i(osr_code_i),
    .raw_i(raw_i), .auto_rst_i(auto_rst_i), .srst_set_i(srst_set_i),
    .meas_start_o(meas_start_o), .meas_busy_o(meas_busy_o), .meas_done_o(meas_done_o),
    .trig_bit_o(trig_bit_o), .srst_bit_o(srst_bit_o), .sysmod_o(sysmod_o)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) tick_en_i <= gap_mode ? ~tick_en_i : 1'b1;

  function automatic int exp_period(int rate, int osr); return BASE << (osr + rate); endfunction
  function automatic int exp_fast(int osr);  return BASE << osr; endfunction
  function automatic int exp_busy(int osr);  return SLOT << osr; endfunction
  function automatic int exp_mode(bit run, bit raw); return !run ? 0 : (raw ? 1 : 2); endfunction

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic wait_start(output int t, output bit srst_before);
    bit p;
    p = srst_bit_o;
    t = -1;
    srst_before = 1'b0;
    for (int k = 0; k < 20000; k++) begin
      @(negedge clk);
      if (meas_start_o) begin
        t = cyc;
        srst_before = p;
        break;
      end
      p = srst_bit_o;
    end
  endtask

  // Counts busy cycles starting in the current (start) cycle; returns at done cycle.
  task automatic count_busy(output int b, output bit done_seen);
    b = 0;
    while (meas_busy_o && b < 5000) begin
      b++;
      @(negedge clk);
    end
    done_seen = meas_done_o;
  endtask

  task automatic count_starts(input int n, output int s);
    s = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (meas_start_o) s++;
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired (all requirements) actual=%0d expected=0", cyc);
      summary();
      $finish;
    end
  end

  initial begin
    int t0, t1, t2, b, s, rate, osr;
    bit sb, dn, rw, au;
    int unsigned seed_v;
    seed_v = $urandom(32'd20117);

    repeat (4) @(negedge clk);
    chk(!meas_start_o && !meas_busy_o && !meas_done_o, "R1 reset pulses", int'(meas_busy_o), 0);
    rst = 1'b0;
    @(negedge clk);
    chk({meas_start_o, meas_busy_o, meas_done_o, trig_bit_o, srst_bit_o} == 5'b0,
        "R1 outputs after reset", int'({meas_start_o, meas_busy_o, meas_done_o, trig_bit_o, srst_bit_o}), 0);
    chk(sysmod_o == 2'b00, "R1 mode after reset", int'(sysmod_o), 0);

    count_starts(150, s);
    chk(s == 0, "R2 standby idle", s, 0);

    // Random configurations in continuous mode
    for (int i = 0; i < 6; i++) begin
      rate = int'($urandom % 4); osr = int'($urandom % 4);
      rw = 1'($urandom % 2); au = 1'($urandom % 2);
      @(negedge clk);
      rate_code_i = 3'(rate); osr_code_i = 2'(osr); raw_i = rw; auto_rst_i = au;
      active_i = 1'b1;
      wait_start(t0, sb);
      count_busy(b, dn);
      chk(b == exp_busy(osr), "R4 busy length", b, exp_busy(osr));
      chk(dn, "R4 done after busy", int'(dn), 1);
      chk(int'(sysmod_o) == exp_mode(1'b1, rw), "R8 active mode code", int'(sysmod_o), exp_mode(1'b1, rw));
      wait_start(t1, sb);
      chk(t1 - t0 == exp_period(rate, osr), "R3 start spacing", t1 - t0, exp_period(rate, osr));
      chk(sb == au, "R10 reset before start", int'(sb), int'(au));
      @(negedge clk);
      active_i = 1'b0;
      repeat (80) @(negedge clk);
      chk(sysmod_o == 2'b00 && !meas_busy_o, "R11 back to standby", int'(sysmod_o), 0);
      count_starts(300, s);
      chk(s == 0, "R2 no start in standby", s, 0);
    end

    // Gapped timebase: only tick cycles count
    @(negedge clk);
    gap_mode = 1'b1; rate_code_i = 3'd1; osr_code_i = 2'd1; auto_rst_i = 1'b0; raw_i = 1'b1;
    active_i = 1'b1;
    wait_start(t0, sb);
    count_busy(b, dn);
    chk(b == 2 * exp_busy(1), "R4 busy with gapped ticks", b, 2 * exp_busy(1));
    wait_start(t1, sb);
    chk(t1 - t0 == 2 * exp_period(1, 1), "R3 spacing with gapped ticks", t1 - t0, 2 * exp_period(1, 1));
    active_i = 1'b0;
    repeat (100) @(negedge clk);
    gap_mode = 1'b0;
    repeat (4) @(negedge clk);

    // Standby trigger, second request during it is not queued
    rate_code_i = 3'd7; osr_code_i = 2'd3; raw_i = 1'b0;
    trig_set_i = 1'b1;
    @(negedge clk);
    trig_set_i = 1'b0;
    t2 = cyc;
    wait_start(t0, sb);
    chk(t0 == t2 + 1, "R5 standby trigger starts at once", t0 - t2, 1);
    chk(trig_bit_o, "R7 trigger bit set", int'(trig_bit_o), 1);
    chk(sysmod_o == 2'b10, "R8 mode during triggered run", int'(sysmod_o), 2);
    trig_set_i = 1'b1;
    @(negedge clk);
    trig_set_i = 1'b0;
    count_busy(b, dn);
    b = b + 1;
    chk(b == exp_busy(3), "R4 triggered busy length", b, exp_busy(3));
    chk(dn && !trig_bit_o, "R7 trigger bit clears at done", int'(trig_bit_o), 0);
    count_starts(300, s);
    chk(s == 0, "R5 single triggered acquisition", s, 0);
    chk(sysmod_o == 2'b00, "R8 standby after trigger", int'(sysmod_o), 0);

    // Continuous-mode trigger
    rate_code_i = 3'd3; osr_code_i = 2'd0; raw_i = 1'b1;
    active_i = 1'b1;
    wait_start(t0, sb);
    wait_start(t0, sb);
    trig_set_i = 1'b1;
    @(negedge clk);
    trig_set_i = 1'b0;
    wait_start(t1, sb);
    chk(t1 - t0 == exp_fast(0), "R6 triggered start at fast spacing", t1 - t0, exp_fast(0));
    chk(trig_bit_o, "R7 bit held during triggered run", int'(trig_bit_o), 1);
    count_busy(b, dn);
    chk(dn && !trig_bit_o, "R7 bit clears after active trigger", int'(trig_bit_o), 0);
    wait_start(t2, sb);
    chk(t2 - t1 == exp_period(3, 0), "R6 programmed rate resumes", t2 - t1, exp_period(3, 0));

    // Clearing active mid-acquisition
    @(negedge clk);
    active_i = 1'b0;
    repeat (80) @(negedge clk);
    rate_code_i = 3'd0; osr_code_i = 2'd3;
    active_i = 1'b1;
    wait_start(t0, sb);
    active_i = 1'b0;
    count_busy(b, dn);
    chk(b == exp_busy(3), "R11 running acquisition completes", b, exp_busy(3));
    chk(dn, "R11 done after active cleared", int'(dn), 1);
    count_starts(300, s);
    chk(s == 0, "R11 no start after active cleared", s, 0);
    chk(sysmod_o == 2'b00, "R11 mode returns to standby", int'(sysmod_o), 0);

    // Manual sensor reset in standby
    srst_set_i = 1'b1;
    @(negedge clk);
    srst_set_i = 1'b0;
    b = 0;
    while (srst_bit_o && b < 100) begin
      b++;
      @(negedge clk);
      if (meas_start_o) s++;
    end
    chk(b == RSTT + 1, "R9 reset bit self-clears", b, RSTT + 1);
    chk(s == 0, "R9 no acquisition from reset", s, 0);

    // Reset request coinciding with a due launch
    rate_code_i = 3'd3; osr_code_i = 2'd0; auto_rst_i = 1'b0; raw_i = 1'b0;
    active_i = 1'b1;
    wait_start(t0, sb);
    wait_start(t0, sb);
    while (cyc < t0 + exp_period(3, 0) - 2) @(negedge clk);
    srst_set_i = 1'b1;
    @(negedge clk);
    srst_set_i = 1'b0;
    wait_start(t1, sb);
    chk(t1 - t0 == exp_period(3, 0) + RSTT, "R12 merged reset delays start", t1 - t0, exp_period(3, 0) + RSTT);
    chk(sb && !srst_bit_o, "R12 reset bit clear at start", int'(srst_bit_o), 0);
    wait_start(t2, sb);
    chk(t2 - t0 == 2 * exp_period(3, 0), "R12 period grid kept", t2 - t0, 2 * exp_period(3, 0));
    active_i = 1'b0;
    repeat (40) @(negedge clk);

    finished = 1'b1;
    summary();
    $finish;
  end

endmodule